// File: doc/BRIEF.md
# Boolean Output On/Off Delay Qualifier

This block qualifies one Boolean signal in time. The raw source bit is first passed through an optional inverter. The result drives a registered output that turns on only after the source has stayed true for an on-delay preset. It turns off only after the source has stayed false for a separate off-delay preset. Both presets are counted in clock ticks. The block also reports, as an integer percentage, how much of the delay now running has elapsed.

A range check watches both presets. If either preset is above the largest allowed value, an error flag is raised. While that condition holds, the output follows the inverted source with no delay. Two inputs clear the output and both timers: dropping the enable, or pulsing the initialize request. This makes the block suitable as the last stage of a configurable interlock path.

Top module: `ovd_qualifier`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs after that edge are `out_q`=0, `pct_done`=0 and `preset_err`=0.
- R2: The effective source is `src_raw` XOR `src_inv`. With `out_q`=0 and on-delay P≥1, `out_q` rises on the P-th consecutive rising edge at which the effective source is 1. Such an edge counts only if `en`=1, `init_req`=0 and no range error holds.
- R3: With `out_q`=1 and off-delay P≥1, `out_q` falls on the P-th consecutive qualifying edge at which the effective source is 0.
- R4: A preset of 0 means no delay. The output takes the new source value at the first qualifying edge, which is the same timing as a preset of 1.
- R5: If the effective source returns to the current `out_q` value before the delay expires, the elapsed count returns to 0. `pct_done` is 0 after that edge and `out_q` is unchanged.
- R6: After each edge, `pct_done` equals floor(elapsed×100/P). Here elapsed is the number of consecutive mismatching edges counted so far, and P is the preset for the direction being timed. `pct_done` is 0 when no delay is running and never exceeds 100.
- R7: After each edge, `preset_err` is 1 exactly when, at that edge, either preset was greater than `MAX_PRESET` (default 2147483). A preset equal to `MAX_PRESET` is valid.
- R8: At an edge where a preset is out of range (with `en`=1 and `init_req`=0), `out_q` takes the effective source value at once and `pct_done` becomes 0.
- R9: At an edge where `en`=0, `out_q` is cleared, both timers are reset and `pct_done` becomes 0.
- R10: At an edge where `init_req`=1, `out_q` is cleared, both timers are reset and `pct_done` becomes 0. Priority is `rst`, then `init_req`, then `en`, then the range error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable; low forces output off and clears timers |
| init_req | input | 1 | Initialize request; clears output and timers |
| src_raw | input | 1 | Raw Boolean source |
| src_inv | input | 1 | Invert the source before qualification |
| on_preset | input | CNT_W | On-delay in ticks |
| off_preset | input | CNT_W | Off-delay in ticks |
| out_q | output | 1 | Qualified output |
| pct_done | output | 7 | Percent of the running delay elapsed |
| preset_err | output | 1 | A preset is out of range |

## Verification
The elapsed counter is hidden, but a wrong value in it shows at the ports within one cycle. `pct_done` tracks the counter after every edge, so a count that is too high, too low or left behind after an abort shows up as a wrong percentage at the next edge. A wrong count also moves the output edge earlier or later than the preset allows. A bad priority between initialize, enable and the range error shows as an `out_q` value that is wrong right after the edge where the conflict occurs. The bench therefore compares all three outputs against its model after every edge.

// File: rtl/ovd_pkg.sv
package ovd_pkg;
  localparam int PCT_W    = 7;
  localparam int PCT_FULL = 100;

  typedef enum logic [2:0] {
    ACT_CLEAR,
    ACT_BYPASS,
    ACT_IDLE,
    ACT_FIRE,
    ACT_COUNT
  } timer_act_e;
endpackage

// File: rtl/ovd_preset_check.sv
module ovd_preset_check #(
  parameter int          CNT_W      = 32,
  parameter int unsigned MAX_PRESET = 2147483
) (
  input  logic [CNT_W-1:0] on_preset,
  input  logic [CNT_W-1:0] off_preset,
  output logic             bad
);
  localparam logic [CNT_W:0] LIMIT = (CNT_W+1)'(MAX_PRESET);

  logic [1:0] over;

  for (genvar i = 0; i < 2; i++) begin : g_cmp
    logic [CNT_W-1:0] p;
    assign p       = (i == 0) ? on_preset : off_preset;
    assign over[i] = {1'b0, p} > LIMIT;
  end

  assign bad = |over;
endmodule

// File: rtl/ovd_delay_timer.sv
module ovd_delay_timer
  import ovd_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             bypass,
  input  logic             src_eff,
  input  logic [CNT_W-1:0] on_preset,
  input  logic [CNT_W-1:0] off_preset,
  output logic             out_q,
  output logic [CNT_W-1:0] cnt_d,
  output logic [CNT_W-1:0] p_sel
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;
  logic             out_d;
  logic             mismatch;
  timer_act_e       act;

  assign p_sel    = src_eff ? on_preset : off_preset;
  assign mismatch = src_eff != out_q;
  assign cnt_inc  = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    if (clear)                          act = ACT_CLEAR;
    else if (bypass)                    act = ACT_BYPASS;
    else if (!mismatch)                 act = ACT_IDLE;
    else if (cnt_inc >= {1'b0, p_sel}) act = ACT_FIRE;
    else                                act = ACT_COUNT;
  end

  always_comb begin
    out_d = out_q;
    cnt_d = '0;
    case (act)
      ACT_CLEAR:  out_d = 1'b0;
      ACT_BYPASS: out_d = src_eff;
      ACT_FIRE:   out_d = src_eff;
      ACT_COUNT:  cnt_d = cnt_inc[CNT_W-1:0];
      default:    out_d = out_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      out_q <= out_d;
      cnt_q <= cnt_d;
    end
  end

  // R9 / R10: clearing forces the output low
  a_r9_clear_forces_off: assert property (@(posedge clk) disable iff (rst)
    clear |=> !out_q);
  // R8: range error makes the output follow the source directly
  a_r8_bypass_follows: assert property (@(posedge clk) disable iff (rst)
    (!clear && bypass) |=> (out_q == $past(src_eff)));
  // R5: a source equal to the output leaves the output unchanged
  a_r5_match_holds: assert property (@(posedge clk) disable iff (rst)
    (!clear && !bypass && !mismatch) |=> $stable(out_q));
  // R4: a zero preset switches at the first qualifying edge
  a_r4_zero_preset: assert property (@(posedge clk) disable iff (rst)
    (!clear && !bypass && mismatch && p_sel == '0) |=> (out_q == $past(src_eff)));
endmodule

// File: rtl/ovd_progress.sv
module ovd_progress
  import ovd_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic [CNT_W-1:0] p_sel,
  output logic [PCT_W-1:0] pct_q
);
  localparam int PROD_W = CNT_W + PCT_W;

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] quot;
  logic [PCT_W-1:0]  pct_d;

  assign prod = PROD_W'(cnt_d) * PROD_W'(PCT_FULL);

  always_comb begin
    quot  = '0;
    pct_d = '0;
    if (cnt_d != '0 && p_sel != '0) begin
      quot = prod / PROD_W'(p_sel);
      if (quot > PROD_W'(PCT_FULL)) pct_d = PCT_W'(PCT_FULL);
      else                          pct_d = quot[PCT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pct_q <= '0;
    else     pct_q <= pct_d;
  end

  // R6: progress never exceeds full scale
  a_r6_pct_cap: assert property (@(posedge clk) disable iff (rst)
    pct_q <= PCT_W'(PCT_FULL));
  // R6: no running delay reads as zero progress
  a_r6_idle_zero: assert property (@(posedge clk) disable iff (rst)
    (cnt_d == '0) |=> (pct_q == '0));
endmodule

// File: rtl/ovd_qualifier.sv
module ovd_qualifier
  import ovd_pkg::*;
#(
  parameter int          CNT_W      = 32,
  parameter int unsigned MAX_PRESET = 2147483
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             init_req,
  input  logic             src_raw,
  input  logic             src_inv,
  input  logic [CNT_W-1:0] on_preset,
  input  logic [CNT_W-1:0] off_preset,
  output logic             out_q,
  output logic [PCT_W-1:0] pct_done,
  output logic             preset_err
);
  logic             bad;
  logic             src_eff;
  logic             clear;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] p_sel;

  assign src_eff = src_raw ^ src_inv;
  assign clear   = init_req | ~en;

  ovd_preset_check #(.CNT_W(CNT_W), .MAX_PRESET(MAX_PRESET)) u_chk (
    .on_preset (on_preset),
    .off_preset(off_preset),
    .bad       (bad)
  );

  ovd_delay_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk       (clk),
    .rst       (rst),
    .clear     (clear),
    .bypass    (bad),
    .src_eff   (src_eff),
    .on_preset (on_preset),
    .off_preset(off_preset),
    .out_q     (out_q),
    .cnt_d     (cnt_d),
    .p_sel     (p_sel)
  );

  ovd_progress #(.CNT_W(CNT_W)) u_pct (
    .clk  (clk),
    .rst  (rst),
    .cnt_d(cnt_d),
    .p_sel(p_sel),
    .pct_q(pct_done)
  );

  always_ff @(posedge clk) begin
    if (rst) preset_err <= 1'b0;
    else     preset_err <= bad;
  end

  // R7: an on-delay above the limit raises the flag on the next edge
  a_r7_over_flags: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, on_preset} > (CNT_W+1)'(MAX_PRESET)) |=> preset_err);
  // R10: initialize clears progress and output together
  a_r10_init_clears: assert property (@(posedge clk) disable iff (rst)
    init_req |=> (!out_q && pct_done == '0));
endmodule

// File: tb/sim_ovd_qualifier.sv
`timescale 1ns/1ps
module sim_ovd_qualifier;
  localparam int          CNT_W = 32;
  localparam int unsigned MAXP  = 2147483;

  logic             clk = 1'b0;
  logic             rst, en, init_req, src_raw, src_inv;
  logic [CNT_W-1:0] on_preset, off_preset;
  logic             out_q, preset_err;
  logic [6:0]       pct_done;

  int    n_vec = 0, n_bad = 0, cyc = 0;
  string phase = "R1";

  longint m_cnt = 0;
  int     m_out = 0, m_pct = 0, m_err = 0;

  always #2.5 clk = ~clk;

  ovd_qualifier #(.CNT_W(CNT_W), .MAX_PRESET(MAXP)) u0 (
    .clk(clk), .rst(rst), .en(en), .init_req(init_req),
    .src_raw(src_raw), .src_inv(src_inv),
    .on_preset(on_preset), .off_preset(off_preset),
    .out_q(out_q), .pct_done(pct_done), .preset_err(preset_err)
  );

  // behavioural reference model
  always @(posedge clk) begin
    int     s, bad;
    longint p;
    s   = int'(src_raw ^ src_inv);
    p   = s ? longint'(on_preset) : longint'(off_preset);
    bad = (longint'(on_preset) > longint'(MAXP)) || (longint'(off_preset) > longint'(MAXP));
    if (rst) begin
      m_out = 0; m_cnt = 0; m_pct = 0; m_err = 0;
    end else begin
      m_err = bad;
      if (init_req || !en)      begin m_out = 0; m_cnt = 0; end
      else if (bad)             begin m_out = s; m_cnt = 0; end
      else if (s == m_out)      m_cnt = 0;
      else if (m_cnt + 1 >= p)  begin m_out = s; m_cnt = 0; end
      else                      m_cnt = m_cnt + 1;
      if (m_cnt == 0 || p == 0) m_pct = 0;
      else                      m_pct = int'((m_cnt * 100) / p);
      if (m_pct > 100) m_pct = 100;
    end
  end

  task automatic step();
    @(negedge clk);
    n_vec++;
    if (int'(out_q) != m_out || int'(pct_done) != m_pct || int'(preset_err) != m_err) begin
      n_bad++;
      $display("FAIL %s cyc %0d: out=%0d pct=%0d err=%0d expected out=%0d pct=%0d err=%0d",
               phase, cyc, out_q, pct_done, preset_err, m_out, m_pct, m_err);
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1; en = 1; init_req = 0; src_raw = 0; src_inv = 0;
    on_preset = 5; off_preset = 3;
    phase = "R1"; run(3);                      // reset state
    rst = 0;
    phase = "R2"; src_raw = 1; run(8);         // on-delay of 5
    phase = "R3"; src_raw = 0; run(6);         // off-delay of 3
    phase = "R5"; src_raw = 1; run(3); src_raw = 0; run(2);
    src_raw = 1; run(7);
    phase = "R5"; src_raw = 0; run(2); src_raw = 1; run(3);
    phase = "R4"; on_preset = 0; off_preset = 1;
    for (int i = 0; i < 6; i++) begin src_raw = i[0]; run(2); end
    phase = "R6"; on_preset = 7; off_preset = 13; src_raw = 0; run(2);
    src_raw = 1; run(9);
    src_inv = 1; run(15);                      // inversion starts an off timing
    src_inv = 0; run(3);
    phase = "R7"; on_preset = MAXP; src_raw = 0; run(3);
    on_preset = MAXP + 1; run(2);
    phase = "R8"; src_raw = 1; run(2); src_raw = 0; run(2);
    off_preset = 32'hFFFF_FFFF; on_preset = 4; src_raw = 1; run(2);
    phase = "R7"; off_preset = 6; run(6);
    phase = "R9"; src_raw = 0; run(3); en = 0; run(3); en = 1; run(8);
    phase = "R10"; src_raw = 1; run(2); init_req = 1; run(1); init_req = 0; run(6);
    init_req = 1; en = 0; on_preset = MAXP + 5; run(2); init_req = 0; en = 1; run(2);
    phase = "R2"; on_preset = 3; off_preset = 2;
    for (int i = 0; i < 400; i++) begin
      src_raw  = $urandom_range(0, 3) != 0 ? src_raw : ~src_raw;
      src_inv  = ($urandom_range(0, 40) == 0) ? ~src_inv : src_inv;
      en       = $urandom_range(0, 50) != 0;
      init_req = $urandom_range(0, 60) == 0;
      step();
    end
    phase = "R1"; rst = 1; run(2); rst = 0;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule